// File: doc/BRIEF.md
# Serial Port Controller with Fractional Baud Divider

This block is an asynchronous serial port that sits on a 32-bit register bus. Software writes characters into a transmit queue and reads received characters out of a receive queue. One line-control bit decides whether each queue is a 16-entry FIFO or a single-byte holding register. Framing is fixed: one low start bit, 5 to 8 data bits sent least significant bit first, and one high stop bit.

Bit timing comes from a 16x oversampling tick. The tick period is an integer count of input clocks plus a 6-bit fraction in 64ths. The fraction is accumulated, and every time the accumulator overflows, one tick period is stretched by a clock. The receiver samples each bit at tick 8 of 16. Clearing the global enable or a direction enable takes effect only between characters, so a character already on the line always finishes.

A pending-event vector records received characters, finished transmissions, framing errors and overruns. Writing ones to the clear register clears the matching flags.

Top module: `uart_fracbaud`

## Requirements
- R1: After reset, the flag register (offset 0x18) reads 0x90: bit 7 is transmit-empty and bit 4 is receive-empty. The serial output is high and the pending vector is zero.
- R2: The 16x tick period averages (integer divisor + fractional divisor/64) clocks. The serial output changes only in the cycle that follows a tick. With divisors 26 and 3, seven bit periods take 2916 to 2919 clocks.
- R3: A byte written to the data register (offset 0x00) goes out as a low start bit, the data bits LSB first, and a high stop bit. Looped back, the same byte is read from the data register.
- R4: Line-control bits [6:5] set the word length: 00 is 5 bits, 01 is 6, 10 is 7, 11 is 8. Unused upper data bits are not sent, and they read back as 0.
- R5: With line-control bit 4 set, each FIFO holds 16 entries. Flag bit 5 (transmit-full) rises when the 16th entry is written, and a 17th write is dropped.
- R6: With line-control bit 4 clear, each direction holds one byte. One write sets flag bit 5 and clears flag bit 7, and a second write is dropped.
- R7: Reading the data register while the receive side is empty returns 0 and leaves the flags unchanged.
- R8: Control bit 0 is the global enable, bit 8 the transmit enable and bit 9 the receive enable. Clearing the transmit enable during a character lets that character finish, and no further character starts.
- R9: A start bit that is no longer low at mid-bit is rejected, and no character is received.
- R10: Pending bit 4 is set by a received character and bit 5 by a finished transmission. Writing ones to bits [10:0] of the clear register (offset 0x44) clears the matching pending bits.
- R11: A low stop bit sets pending bit 7 (framing error). The character is still stored.
- R12: A character that arrives while the receive side is full is dropped, the stored data is kept, and pending bit 10 (overrun) is set.
- R13: Writing line control with a changed FIFO-enable bit flushes both queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, valid in the read-strobe cycle |
| ser_rx | input | 1 | Serial receive line |
| ser_tx | output | 1 | Serial transmit line |
| int_pend | output | 11 | Pending event flags |

## Verification
Two collisions are targeted.

The first is a bus write to the data register in the same cycle the transmitter pops its queue. The bench polls transmit-empty and writes the next byte immediately, so the write lands while the engine is fetching. A scoreboard queue, filled by the write task and drained by a line monitor, confirms that every accepted byte appears on the line exactly once and in order.

The second is a receive push meeting a full holding register. Two back-to-back looped frames are sent with no read in between. The bench then judges that the first byte survives, the second byte is gone, and the overrun flag is set.

// File: rtl/ufb_pkg.sv
package ufb_pkg;
   localparam int OFS_DATA = 'h00;
   localparam int OFS_FLAG = 'h18;
   localparam int OFS_IDIV = 'h24;
   localparam int OFS_FDIV = 'h28;
   localparam int OFS_LINE = 'h2C;
   localparam int OFS_CTRL = 'h30;
   localparam int OFS_ICLR = 'h44;

   localparam int EV_RX  = 4;
   localparam int EV_TX  = 5;
   localparam int EV_FRM = 7;
   localparam int EV_OVR = 10;
   localparam int EV_W   = 11;

   typedef enum logic [1:0] {LN_IDLE, LN_START, LN_DATA, LN_STOP} line_st_e;
endpackage

// File: rtl/ufb_baud.sv
module ufb_baud #(
   parameter int IW = 16,
   parameter int FW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] idiv,
   input  logic [FW-1:0] fdiv,
   output logic          tick
);
   logic [IW:0]   cnt;
   logic [FW-1:0] acc;
   logic          stretch;
   logic [IW:0]   limit;
   logic [FW:0]   sum;

   assign limit = {1'b0, idiv} + {{IW{1'b0}}, stretch};
   assign sum   = {1'b0, acc} + {1'b0, fdiv};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         acc     <= '0;
         stretch <= 1'b0;
         tick    <= 1'b0;
      end else begin
         tick <= 1'b0;
         if (idiv == '0) begin
            cnt <= '0;
         end else if (cnt + 1'b1 >= limit) begin
            cnt     <= '0;
            tick    <= 1'b1;
            acc     <= sum[FW-1:0];
            stretch <= sum[FW];
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ufb_fifo.sv
module ufb_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          one_deep,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic          empty,
   output logic          full,
   output logic [CW-1:0] count
);
   generate
      if ((1 << PW) != DEPTH || DEPTH < 2) begin : g_bad_depth
         $error("ufb_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = one_deep ? (count != '0) : (count == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp] <= din;
   end
endmodule

// File: rtl/ufb_tx.sv
module ufb_tx
   import ufb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       enable,
   input  logic [3:0] nbits,
   input  logic       have,
   input  logic [7:0] din,
   output logic       pop,
   output logic       txd,
   output logic       done
);
   line_st_e   st;
   logic [3:0] tc;
   logic [2:0] bidx;
   logic [7:0] shreg;

   assign pop = (st == LN_IDLE) && tick && enable && have;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= LN_IDLE;
         txd   <= 1'b1;
         tc    <= '0;
         bidx  <= '0;
         shreg <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            unique case (st)
               LN_IDLE: if (enable && have) begin
                  st    <= LN_START;
                  txd   <= 1'b0;
                  tc    <= '0;
                  shreg <= din;
               end
               LN_START: begin
                  tc <= tc + 1'b1;
                  if (tc == 4'd15) begin
                     st   <= LN_DATA;
                     txd  <= shreg[0];
                     bidx <= '0;
                  end
               end
               LN_DATA: begin
                  tc <= tc + 1'b1;
                  if (tc == 4'd15) begin
                     if (bidx == 3'(nbits - 4'd1)) begin
                        st  <= LN_STOP;
                        txd <= 1'b1;
                     end else begin
                        bidx  <= bidx + 1'b1;
                        shreg <= shreg >> 1;
                        txd   <= shreg[1];
                     end
                  end
               end
               LN_STOP: begin
                  tc <= tc + 1'b1;
                  if (tc == 4'd15) begin
                     st   <= LN_IDLE;
                     done <= 1'b1;
                  end
               end
               default: st <= LN_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/ufb_rx.sv
module ufb_rx
   import ufb_pkg::*;
#(
   parameter int SYNC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       enable,
   input  logic [3:0] nbits,
   input  logic       rxd,
   output logic       push,
   output logic [7:0] dout,
   output logic       ferr
);
   generate
      if (SYNC < 2) begin : g_bad_sync
         $error("ufb_rx: SYNC must be at least 2");
      end
   endgenerate

   logic [SYNC-1:0] sy;
   logic            rxs;
   line_st_e        st;
   logic [3:0]      tc;
   logic [2:0]      bidx;

   assign rxs = sy[SYNC-1];

   always_ff @(posedge clk) begin
      if (!rst_n) sy <= '1;
      else        sy <= {sy[SYNC-2:0], rxd};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= LN_IDLE;
         tc   <= '0;
         bidx <= '0;
         dout <= '0;
         push <= 1'b0;
         ferr <= 1'b0;
      end else begin
         push <= 1'b0;
         unique case (st)
            LN_IDLE: if (enable && !rxs) begin
               st   <= LN_START;
               tc   <= '0;
               dout <= '0;
            end
            LN_START: if (tick) begin
               if (tc == 4'd7) begin
                  tc   <= '0;
                  bidx <= '0;
                  st   <= rxs ? LN_IDLE : LN_DATA;
               end else begin
                  tc <= tc + 1'b1;
               end
            end
            LN_DATA: if (tick) begin
               tc <= tc + 1'b1;
               if (tc == 4'd15) begin
                  dout[bidx] <= rxs;
                  if (bidx == 3'(nbits - 4'd1)) st <= LN_STOP;
                  else                          bidx <= bidx + 1'b1;
               end
            end
            LN_STOP: if (tick) begin
               tc <= tc + 1'b1;
               if (tc == 4'd15) begin
                  st   <= LN_IDLE;
                  push <= 1'b1;
                  ferr <= !rxs;
               end
            end
            default: st <= LN_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/uart_fracbaud.sv
module uart_fracbaud
   import ufb_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int BUS_W      = 32,
   parameter int FIFO_DEPTH = 16,
   parameter int IDIV_W     = 16,
   parameter int FDIV_W     = 6,
   parameter int SYNC       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              ser_rx,
   output logic              ser_tx,
   output logic [10:0]       int_pend
);
   localparam int CW = $clog2(FIFO_DEPTH + 1);

   generate
      if (ADDR_W < 7 || BUS_W < IDIV_W || BUS_W < EV_W) begin : g_bad_bus
         $error("uart_fracbaud: bus too narrow for the register map");
      end
   endgenerate

   logic [IDIV_W-1:0] idiv_q;
   logic [FDIV_W-1:0] fdiv_q;
   logic [1:0]        wlen_q;
   logic              fen_q;
   logic              en_q, txe_q, rxe_q;

   logic wr_data, wr_idiv, wr_fdiv, wr_line, wr_ctrl, wr_iclr, rd_data;
   assign wr_data = bus_wr && bus_addr == ADDR_W'(OFS_DATA);
   assign wr_idiv = bus_wr && bus_addr == ADDR_W'(OFS_IDIV);
   assign wr_fdiv = bus_wr && bus_addr == ADDR_W'(OFS_FDIV);
   assign wr_line = bus_wr && bus_addr == ADDR_W'(OFS_LINE);
   assign wr_ctrl = bus_wr && bus_addr == ADDR_W'(OFS_CTRL);
   assign wr_iclr = bus_wr && bus_addr == ADDR_W'(OFS_ICLR);
   assign rd_data = bus_rd && bus_addr == ADDR_W'(OFS_DATA);

   logic flush;
   assign flush = wr_line && (bus_wdata[4] != fen_q);

   logic [3:0] nbits;
   assign nbits = 4'd5 + {2'b00, wlen_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idiv_q <= '0;
         fdiv_q <= '0;
         wlen_q <= '0;
         fen_q  <= 1'b0;
         en_q   <= 1'b0;
         txe_q  <= 1'b1;
         rxe_q  <= 1'b1;
      end else begin
         if (wr_idiv) idiv_q <= bus_wdata[IDIV_W-1:0];
         if (wr_fdiv) fdiv_q <= bus_wdata[FDIV_W-1:0];
         if (wr_line) begin
            wlen_q <= bus_wdata[6:5];
            fen_q  <= bus_wdata[4];
         end
         if (wr_ctrl) begin
            en_q  <= bus_wdata[0];
            txe_q <= bus_wdata[8];
            rxe_q <= bus_wdata[9];
         end
      end
   end

   logic tick16;
   ufb_baud #(.IW(IDIV_W), .FW(FDIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .idiv(idiv_q), .fdiv(fdiv_q), .tick(tick16)
   );

   logic          tx_pop, tx_empty, tx_full, tx_done;
   logic [7:0]    tx_head;
   logic [CW-1:0] tx_cnt;
   ufb_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(flush), .one_deep(!fen_q),
      .push(wr_data), .din(bus_wdata[7:0]), .pop(tx_pop),
      .dout(tx_head), .empty(tx_empty), .full(tx_full), .count(tx_cnt)
   );

   ufb_tx u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .enable(en_q && txe_q),
      .nbits(nbits), .have(!tx_empty), .din(tx_head),
      .pop(tx_pop), .txd(ser_tx), .done(tx_done)
   );

   logic          rx_push, rx_ferr, rx_empty, rx_full;
   logic [7:0]    rx_byte, rx_head;
   logic [CW-1:0] rx_cnt;
   ufb_rx #(.SYNC(SYNC)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .enable(en_q && rxe_q),
      .nbits(nbits), .rxd(ser_rx), .push(rx_push), .dout(rx_byte), .ferr(rx_ferr)
   );

   ufb_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(flush), .one_deep(!fen_q),
      .push(rx_push), .din(rx_byte), .pop(rd_data),
      .dout(rx_head), .empty(rx_empty), .full(rx_full), .count(rx_cnt)
   );

   logic [EV_W-1:0] ev_set, ev_clr;
   always_comb begin
      ev_set         = '0;
      ev_set[EV_RX]  = rx_push;
      ev_set[EV_TX]  = tx_done;
      ev_set[EV_FRM] = rx_push && rx_ferr;
      ev_set[EV_OVR] = rx_push && rx_full;
      ev_clr         = wr_iclr ? bus_wdata[EV_W-1:0] : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) int_pend <= '0;
      else        int_pend <= (int_pend & ~ev_clr) | ev_set;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         unique case (bus_addr)
            ADDR_W'(OFS_DATA): bus_rdata[7:0] = rx_empty ? 8'h00 : rx_head;
            ADDR_W'(OFS_FLAG): begin
               bus_rdata[7] = tx_empty;
               bus_rdata[5] = tx_full;
               bus_rdata[4] = rx_empty;
            end
            ADDR_W'(OFS_IDIV): bus_rdata[IDIV_W-1:0] = idiv_q;
            ADDR_W'(OFS_FDIV): bus_rdata[FDIV_W-1:0] = fdiv_q;
            ADDR_W'(OFS_LINE): bus_rdata[6:4] = {wlen_q, fen_q};
            ADDR_W'(OFS_CTRL): begin
               bus_rdata[0] = en_q;
               bus_rdata[8] = txe_q;
               bus_rdata[9] = rxe_q;
            end
            default: bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/ufb_chk.sv
module ufb_chk #(
   parameter int AW    = 8,
   parameter int DEPTH = 16,
   parameter int CW    = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick,
   input logic          ser_tx,
   input logic          tx_empty,
   input logic          tx_full,
   input logic          fen,
   input logic [CW-1:0] rx_cnt,
   input logic          rx_empty,
   input logic          rx_push,
   input logic          bus_wr,
   input logic          bus_rd,
   input logic [AW-1:0] bus_addr,
   input logic [31:0]   bus_wdata,
   input logic [31:0]   bus_rdata,
   input logic [10:0]   int_pend
);
   AST_TX_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ser_tx) |-> $past(tick)); // R2

   AST_TX_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_empty && tx_full)); // R6

   AST_RX_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      rx_cnt <= (fen ? CW'(DEPTH) : CW'(1))); // R5

   AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == AW'('h00) && rx_empty) |-> bus_rdata == 32'h0); // R7

   AST_ICR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == AW'('h44) && bus_wdata[4] && !rx_push) |=> !int_pend[4]); // R10
endmodule

bind uart_fracbaud ufb_chk #(.AW(ADDR_W), .DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick16), .ser_tx(ser_tx),
   .tx_empty(tx_empty), .tx_full(tx_full), .fen(fen_q), .rx_cnt(rx_cnt),
   .rx_empty(rx_empty), .rx_push(rx_push), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .int_pend(int_pend)
);

// File: tb/sim_uart_fracbaud.sv
module sim_uart_fracbaud;
   localparam logic [7:0] A_DATA = 8'h00, A_FLAG = 8'h18, A_IDIV = 8'h24,
                          A_FDIV = 8'h28, A_LINE = 8'h2C, A_CTRL = 8'h30,
                          A_ICLR = 8'h44;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        ser_tx, ser_rx;
   logic [10:0] int_pend;
   logic        lb = 1'b1, force_val = 1'b1;

   int   n_chk = 0, n_bad = 0;
   int   mon_bits = 8;
   bit   mon_en = 1'b1;
   logic [7:0] exp_q [$];

   always #5 clk = ~clk;
   assign ser_rx = lb ? ser_tx : force_val;

   uart_fracbaud u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ser_rx(ser_rx), .ser_tx(ser_tx), .int_pend(int_pend)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   // driver: writes a byte and queues what the line must carry
   task automatic send_byte(input logic [7:0] b);
      wr(A_DATA, {24'h0, b});
      exp_q.push_back(b & 8'((1 << mon_bits) - 1));
   endtask

   task automatic wait_idle();
      wait (exp_q.size() == 0);
      repeat (120) @(negedge clk);
   endtask

   task automatic drive_frame(input logic [7:0] b, input bit good_stop);
      @(negedge clk);
      force_val = 1'b0;
      repeat (40) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         force_val = b[i];
         repeat (40) @(negedge clk);
      end
      force_val = good_stop;
      repeat (good_stop ? 40 : 30) @(negedge clk);
      force_val = 1'b1;
      repeat (100) @(negedge clk);
   endtask

   // monitor: decodes the line at 40 clocks per bit and scores it
   initial begin
      forever begin
         logic [7:0] got;
         logic [7:0] want;
         @(negedge ser_tx);
         if (!mon_en) continue;
         got = '0;
         repeat (20) @(negedge clk);
         chk(ser_tx == 1'b0, "R3 start bit low", {31'h0, ser_tx}, 32'h0);
         for (int i = 0; i < mon_bits; i++) begin
            repeat (40) @(negedge clk);
            got[i] = ser_tx;
         end
         repeat (40) @(negedge clk);
         chk(ser_tx == 1'b1, "R3 stop bit high", {31'h0, ser_tx}, 32'h1);
         if (exp_q.size() == 0) begin
            chk(1'b0, "R3 unexpected character", {24'h0, got}, 32'h0);
         end else begin
            want = exp_q.pop_front();
            chk(got == want, "R3/R4 line character", {24'h0, got}, {24'h0, want});
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      time t0, t1;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_FLAG, d);
      chk(d == 32'h90, "R1 reset flags", d, 32'h90);
      chk(ser_tx == 1'b1, "R1 idle line", {31'h0, ser_tx}, 32'h1);
      chk(int_pend == '0, "R1 pending clear", {21'h0, int_pend}, 32'h0);

      wr(A_IDIV, 32'd2);
      wr(A_FDIV, 32'd32);
      wr(A_LINE, 32'h70);
      wr(A_CTRL, 32'h301);

      // R3 loopback, 8 bits
      send_byte(8'hA5);
      send_byte(8'h3C);
      wait_idle();
      rd(A_DATA, d); chk(d == 32'hA5, "R3 receive first", d, 32'hA5);
      rd(A_DATA, d); chk(d == 32'h3C, "R3 receive second", d, 32'h3C);
      // R7 empty read
      rd(A_DATA, d); chk(d == 32'h0, "R7 empty read", d, 32'h0);
      rd(A_FLAG, d); chk(d == 32'h90, "R7 flags unchanged", d, 32'h90);

      // R10 event flags and clear
      chk(int_pend[4] && int_pend[5], "R10 events set", {21'h0, int_pend}, 32'h30);
      wr(A_ICLR, 32'h7FF);
      chk(int_pend == '0, "R10 cleared", {21'h0, int_pend}, 32'h0);

      // R4 word lengths
      wr(A_LINE, 32'h10); mon_bits = 5;
      send_byte(8'hFF);
      wait_idle();
      rd(A_DATA, d); chk(d == 32'h1F, "R4 5-bit receive", d, 32'h1F);
      wr(A_LINE, 32'h50); mon_bits = 7;
      send_byte(8'hD2);
      wait_idle();
      rd(A_DATA, d); chk(d == 32'h52, "R4 7-bit receive", d, 32'h52);

      // R5 16-deep FIFO
      wr(A_LINE, 32'h70); mon_bits = 8;
      wr(A_CTRL, 32'h201);
      for (int i = 0; i < 16; i++) send_byte(8'h40 + 8'(i));
      rd(A_FLAG, d); chk(d[5] == 1'b1, "R5 full after 16", d, 32'h20);
      wr(A_DATA, 32'hEE);
      wr(A_CTRL, 32'h301);
      wait_idle();
      for (int i = 0; i < 16; i++) begin
         rd(A_DATA, d);
         chk(d == 32'h40 + 32'(i), "R5 receive order", d, 32'h40 + 32'(i));
      end
      chk(int_pend[10] == 1'b0, "R5 no overrun", {21'h0, int_pend}, 32'h0);

      // R8 disable mid-character
      wr(A_CTRL, 32'h201);
      wr(A_DATA, 32'h11);
      wr(A_DATA, 32'h22);
      exp_q.push_back(8'h11);
      wr(A_CTRL, 32'h301);
      repeat (100) @(negedge clk);
      wr(A_CTRL, 32'h201);
      wait_idle();
      repeat (700) @(negedge clk);
      rd(A_FLAG, d); chk(d[7] == 1'b0, "R8 next char held", d, 32'h0);
      chk(ser_tx == 1'b1, "R8 line idle", {31'h0, ser_tx}, 32'h1);
      exp_q.push_back(8'h22);
      wr(A_CTRL, 32'h301);
      wait_idle();
      rd(A_DATA, d); chk(d == 32'h11, "R8 finished char", d, 32'h11);
      rd(A_DATA, d); chk(d == 32'h22, "R8 resumed char", d, 32'h22);

      // R13 flush on FIFO-mode change
      wr(A_CTRL, 32'h201);
      wr(A_DATA, 32'h01); wr(A_DATA, 32'h02); wr(A_DATA, 32'h03);
      rd(A_FLAG, d); chk(d[7] == 1'b0, "R13 queued", d, 32'h0);
      wr(A_LINE, 32'h60);
      rd(A_FLAG, d); chk(d == 32'h90, "R13 flushed", d, 32'h90);

      // R6 holding register
      send_byte(8'h77);
      rd(A_FLAG, d); chk(d == 32'h30, "R6 holding full", d, 32'h30);
      wr(A_DATA, 32'h88);
      wr(A_CTRL, 32'h301);
      wait_idle();
      rd(A_DATA, d); chk(d == 32'h77, "R6 single byte", d, 32'h77);
      rd(A_FLAG, d); chk(d == 32'h90, "R6 second dropped", d, 32'h90);

      // R12 overrun: write lands as the transmitter fetches
      wr(A_ICLR, 32'h7FF);
      send_byte(8'h5A);
      do rd(A_FLAG, d); while (d[7] == 1'b0);
      send_byte(8'h6B);
      wait_idle();
      rd(A_DATA, d); chk(d == 32'h5A, "R12 first kept", d, 32'h5A);
      chk(int_pend[10] == 1'b1, "R12 overrun flag", {21'h0, int_pend}, 32'h400);
      rd(A_DATA, d); chk(d == 32'h0, "R12 second dropped", d, 32'h0);

      // R9 glitch rejection
      lb = 1'b0;
      wr(A_ICLR, 32'h7FF);
      @(negedge clk); force_val = 1'b0;
      repeat (10) @(negedge clk); force_val = 1'b1;
      repeat (800) @(negedge clk);
      rd(A_FLAG, d); chk(d[4] == 1'b1, "R9 nothing received", d, 32'h10);
      chk(int_pend[4] == 1'b0, "R9 no rx event", {21'h0, int_pend}, 32'h0);

      // R11 framing error
      drive_frame(8'h81, 1'b0);
      chk(int_pend[7] == 1'b1, "R11 framing flag", {21'h0, int_pend}, 32'h80);
      rd(A_DATA, d); chk(d == 32'h81, "R11 char stored", d, 32'h81);
      lb = 1'b1;

      // R2 fractional timing: 26 + 3/64
      wr(A_LINE, 32'h70);
      wr(A_IDIV, 32'd26);
      wr(A_FDIV, 32'd3);
      mon_en = 1'b0;
      wr(A_DATA, 32'h55);
      @(negedge ser_tx);
      @(negedge ser_tx);
      t0 = $time;
      repeat (4) @(posedge ser_tx);
      t1 = $time;
      chk((t1 - t0) / 10 >= 2916 && (t1 - t0) / 10 <= 2919, "R2 seven bit periods",
          32'((t1 - t0) / 10), 32'd2917);
      repeat (1000) @(negedge clk);
      rd(A_DATA, d); chk(d == 32'h55, "R2 receive at 26+3/64", d, 32'h55);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule